// File: doc/BRIEF.md
# Test Access Port with Device Status Capture

This block is the boundary-scan test access port of a configuration memory device. A five-state-deep TMS-driven controller walks the standard sixteen-state graph on TCK. A 16-bit instruction register picks one of several data registers to place between TDI and TDO. When the instruction path is captured, the register does not load a plain constant. It loads a status word built from live flags that the memory core drives:
- whether the device is in in-system configuration mode;
- whether an erase or program is running;
- the pass or fail result of the last configuration operation;
- the pass or fail result of the last erase or program;
- whether the selected revision was fully written.

The data registers are a 32-bit identification code, a 32-bit user code, a one-bit bypass and a short boundary-scan chain. The user code reads as all ones when the core reports that no code was loaded. The chain covers a parameterised number of input, output and bidirectional pins. Each pin kind lays out its cells in a fixed order relative to TDO. An external tester drives TCK, TMS, TDI and an optional active-low TRST and reads TDO. TDO carries a separate enable that is active only while shifting.

Top module: `jtag_status_tap`

## Requirements
- R1: The controller reaches Test-Logic-Reset when trst_n is low, or after five rising TCK edges with TMS high, from any state. In Test-Logic-Reset the active instruction becomes the identification instruction, so a data scan with no instruction load returns the identification code.
- R2: The instruction register is 16 bits wide and shifts LSB first: the bit captured in bit 0 leaves TDO first, and TDI enters at bit 15. The captured word always has zeros in bits 15:9 and the pattern 01 in bits 1:0.
- R3: Captured bits 8:7 are 10 when st_isc_pass is 1 and 01 when it is 0. Bits 6:5 use the same two codes for st_ep_pass.
- R4: Captured bit 4 is 0 while st_ep_busy is 1 and 1 otherwise. Bit 3 equals st_isc_mode. Bit 2 equals st_rev_done.
- R5: Instruction 16'h00FE selects a 32-bit identification register. It captures the parameter ID_CODE, whose bit 0 is 1, and shifts it out LSB first.
- R6: Instruction 16'h00FD selects a 32-bit user code register. It captures the usercode input when usercode_valid is 1 and 32'hFFFFFFFF when usercode_valid is 0.
- R7: Instruction 16'hFFFF and every code not listed in R5, R6 or R9 select a one-bit bypass register. This register captures 0, so a scan of N bits returns 0 followed by the first N-1 input bits.
- R8: The boundary chain has 3*NB+2*NO+NI cells, and cell 0 is the one nearest TDO. Bidirectional pin j uses cells 3j (output enable), 3j+1 (output data) and 3j+2 (input). Output pin k uses cell 3NB+2k (enable) and cell 3NB+2k+1 (data). Input pin m uses cell 3NB+2NO+m.
- R9: Instruction 16'h0001 captures the pins into the chain and leaves the pad outputs following the core. Instruction 16'h0000 drives the pad data and enable outputs from the chain's update stage, which is loaded in Update-DR.
- R10: tdo changes only on falling TCK edges. tdo_en is 1 only while the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | TDO drive enable; pad is high-Z when 0 |
| st_isc_mode | input | 1 | Core is in in-system configuration mode |
| st_ep_busy | input | 1 | Erase or program in progress |
| st_isc_pass | input | 1 | Last configuration operation passed |
| st_ep_pass | input | 1 | Last erase or program passed |
| st_rev_done | input | 1 | Selected revision fully programmed |
| usercode | input | 32 | Stored user code |
| usercode_valid | input | 1 | A user code has been stored |
| pin_in | input | NI | Input pin pads |
| core_out | input | NO | Core data for output pins |
| core_oe | input | NO | Core enables for output pins |
| pad_out | output | NO | Output pin pad data |
| pad_oe | output | NO | Output pin pad enables |
| core_bi_out | input | NB | Core data for bidirectional pins |
| core_bi_oe | input | NB | Core enables for bidirectional pins |
| pad_bi_in | input | NB | Bidirectional pad input values |
| pad_bi_out | output | NB | Bidirectional pad data |
| pad_bi_oe | output | NB | Bidirectional pad enables |

## Verification
The assertions assume that the status flags are steady around the rising TCK edge in Capture-IR. They also assume that trst_n is held low across at least one edge before any scan, so the controller state is known. The bench changes every input, including the status flags, only just after a falling edge. It starts each run with trst_n low for two cycles. It then draws flag combinations, user codes, instruction codes and scan data from a seeded $urandom and steers random codes away from the defined ones when it wants the bypass path.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {DR_BYPASS, DR_IDENT, DR_USER, DR_CHAIN} dr_sel_e;

  localparam int IR_W = 16;
  localparam logic [IR_W-1:0] OP_EXTEST   = 16'h0000;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 16'h0001;
  localparam logic [IR_W-1:0] OP_IDENT    = 16'h00FE;
  localparam logic [IR_W-1:0] OP_USER     = 16'h00FD;
  localparam logic [IR_W-1:0] OP_BYPASS   = 16'hFFFF;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    case (s)
      TS_RESET:  return m ? TS_RESET  : TS_IDLE;
      TS_IDLE:   return m ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: return m ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: return m ? TS_EX1_DR : TS_SH_DR;
      TS_SH_DR:  return m ? TS_EX1_DR : TS_SH_DR;
      TS_EX1_DR: return m ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: return m ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: return m ? TS_UPD_DR : TS_SH_DR;
      TS_UPD_DR: return m ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: return m ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: return m ? TS_EX1_IR : TS_SH_IR;
      TS_SH_IR:  return m ? TS_EX1_IR : TS_SH_IR;
      TS_EX1_IR: return m ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: return m ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: return m ? TS_UPD_IR : TS_SH_IR;
      default:   return m ? TS_SEL_DR : TS_IDLE;
    endcase
  endfunction

  // Two-bit result code: pass gives 10, fail gives 01.
  function automatic logic [1:0] result_code(input logic pass);
    return pass ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [IR_W-1:0] status_word(
      input logic isc_pass, input logic ep_pass, input logic ep_busy,
      input logic isc_mode, input logic rev_done);
    return {7'b0, result_code(isc_pass), result_code(ep_pass),
            ~ep_busy, isc_mode, rev_done, 2'b01};
  endfunction

  function automatic dr_sel_e dr_decode(input logic [IR_W-1:0] op);
    case (op)
      OP_IDENT:              return DR_IDENT;
      OP_USER:               return DR_USER;
      OP_EXTEST, OP_SAMPLE:  return DR_CHAIN;
      default:               return DR_BYPASS;
    endcase
  endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= TS_RESET;
    else         state <= tap_next(state, tms);
  end

endmodule

// File: rtl/jtag_tap_ir.sv
module jtag_tap_ir
  import jtag_tap_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  input  logic [IR_W-1:0] cap_word,
  output logic [IR_W-1:0] ir_sr,
  output logic [IR_W-1:0] ir_q
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr <= '0;
    end else if (state == TS_CAP_IR) begin
      ir_sr <= cap_word;
    end else if (state == TS_SH_IR) begin
      ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                 ir_q <= OP_IDENT;
    else if (state == TS_RESET)  ir_q <= OP_IDENT;
    else if (state == TS_UPD_IR) ir_q <= ir_sr;
  end

endmodule

// File: rtl/jtag_tap_bsr.sv
module jtag_tap_bsr #(
  parameter int NI = 2,
  parameter int NO = 2,
  parameter int NB = 2,
  localparam int LEN = 3*NB + 2*NO + NI
) (
  input  logic          tck,
  input  logic          trst_n,
  input  logic          cap_en,
  input  logic          sh_en,
  input  logic          upd_en,
  input  logic          extest,
  input  logic          tdi,
  input  logic [NI-1:0] pin_in,
  input  logic [NO-1:0] core_out,
  input  logic [NO-1:0] core_oe,
  output logic [NO-1:0] pad_out,
  output logic [NO-1:0] pad_oe,
  input  logic [NB-1:0] core_bi_out,
  input  logic [NB-1:0] core_bi_oe,
  input  logic [NB-1:0] pad_bi_in,
  output logic [NB-1:0] pad_bi_out,
  output logic [NB-1:0] pad_bi_oe,
  output logic          sr_lsb
);

  localparam int OBASE = 3*NB;
  localparam int IBASE = OBASE + 2*NO;

  logic [LEN-1:0] cap_v, sr, upd;

  // Bidirectional pins sit nearest TDO: enable, data, input from low to high.
  for (genvar j = 0; j < NB; j++) begin : g_bidir
    assign cap_v[3*j]   = core_bi_oe[j];
    assign cap_v[3*j+1] = core_bi_out[j];
    assign cap_v[3*j+2] = pad_bi_in[j];
    assign pad_bi_oe[j]  = extest ? upd[3*j]   : core_bi_oe[j];
    assign pad_bi_out[j] = extest ? upd[3*j+1] : core_bi_out[j];
  end

  // Output pins: enable nearer TDO, data nearer TDI.
  for (genvar k = 0; k < NO; k++) begin : g_out
    assign cap_v[OBASE+2*k]   = core_oe[k];
    assign cap_v[OBASE+2*k+1] = core_out[k];
    assign pad_oe[k]  = extest ? upd[OBASE+2*k]   : core_oe[k];
    assign pad_out[k] = extest ? upd[OBASE+2*k+1] : core_out[k];
  end

  for (genvar m = 0; m < NI; m++) begin : g_in
    assign cap_v[IBASE+m] = pin_in[m];
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sr  <= '0;
      upd <= '0;
    end else begin
      if (cap_en)     sr <= cap_v;
      else if (sh_en) sr <= {tdi, sr[LEN-1:1]};
      if (upd_en)     upd <= sr;
    end
  end

  assign sr_lsb = sr[0];

endmodule

// File: rtl/jtag_status_tap.sv
module jtag_status_tap
  import jtag_tap_pkg::*;
#(
  parameter int          NI      = 2,
  parameter int          NO      = 2,
  parameter int          NB      = 2,
  parameter logic [31:0] ID_CODE = 32'h1A5C_E093
) (
  input  logic          tck,
  input  logic          trst_n,
  input  logic          tms,
  input  logic          tdi,
  output logic          tdo,
  output logic          tdo_en,
  input  logic          st_isc_mode,
  input  logic          st_ep_busy,
  input  logic          st_isc_pass,
  input  logic          st_ep_pass,
  input  logic          st_rev_done,
  input  logic [31:0]   usercode,
  input  logic          usercode_valid,
  input  logic [NI-1:0] pin_in,
  input  logic [NO-1:0] core_out,
  input  logic [NO-1:0] core_oe,
  output logic [NO-1:0] pad_out,
  output logic [NO-1:0] pad_oe,
  input  logic [NB-1:0] core_bi_out,
  input  logic [NB-1:0] core_bi_oe,
  input  logic [NB-1:0] pad_bi_in,
  output logic [NB-1:0] pad_bi_out,
  output logic [NB-1:0] pad_bi_oe
);

  tap_state_e      state;
  logic [IR_W-1:0] ir_sr, ir_q, cap_word;
  dr_sel_e         dr_sel;
  logic [31:0]     word_sr;
  logic            byp_q, chain_lsb, tdo_nxt;

  // Named internal events, also used by the bound checker.
  logic in_cap_dr, in_sh_dr, in_upd_dr, in_shift;
  assign in_cap_dr = (state == TS_CAP_DR);
  assign in_sh_dr  = (state == TS_SH_DR);
  assign in_upd_dr = (state == TS_UPD_DR);
  assign in_shift  = in_sh_dr || (state == TS_SH_IR);

  assign cap_word = status_word(st_isc_pass, st_ep_pass, st_ep_busy,
                                st_isc_mode, st_rev_done);
  assign dr_sel   = dr_decode(ir_q);

  jtag_tap_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state(state)
  );

  jtag_tap_ir u_ir (
    .tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi),
    .cap_word(cap_word), .ir_sr(ir_sr), .ir_q(ir_q)
  );

  jtag_tap_bsr #(.NI(NI), .NO(NO), .NB(NB)) u_bsr (
    .tck(tck), .trst_n(trst_n),
    .cap_en(in_cap_dr && dr_sel == DR_CHAIN),
    .sh_en(in_sh_dr && dr_sel == DR_CHAIN),
    .upd_en(in_upd_dr && dr_sel == DR_CHAIN),
    .extest(ir_q == OP_EXTEST),
    .tdi(tdi), .pin_in(pin_in),
    .core_out(core_out), .core_oe(core_oe), .pad_out(pad_out), .pad_oe(pad_oe),
    .core_bi_out(core_bi_out), .core_bi_oe(core_bi_oe), .pad_bi_in(pad_bi_in),
    .pad_bi_out(pad_bi_out), .pad_bi_oe(pad_bi_oe), .sr_lsb(chain_lsb)
  );

  // Shared 32-bit shift path for identification and user codes.
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      word_sr <= '0;
    end else if (in_cap_dr && dr_sel == DR_IDENT) begin
      word_sr <= ID_CODE;
    end else if (in_cap_dr && dr_sel == DR_USER) begin
      word_sr <= usercode_valid ? usercode : '1;
    end else if (in_sh_dr && (dr_sel == DR_IDENT || dr_sel == DR_USER)) begin
      word_sr <= {tdi, word_sr[31:1]};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                                byp_q <= 1'b0;
    else if (in_cap_dr && dr_sel == DR_BYPASS)  byp_q <= 1'b0;
    else if (in_sh_dr && dr_sel == DR_BYPASS)   byp_q <= tdi;
  end

  always_comb begin
    tdo_nxt = 1'b0;
    if (state == TS_SH_IR) begin
      tdo_nxt = ir_sr[0];
    end else if (in_sh_dr) begin
      case (dr_sel)
        DR_IDENT, DR_USER: tdo_nxt = word_sr[0];
        DR_CHAIN:          tdo_nxt = chain_lsb;
        default:           tdo_nxt = byp_q;
      endcase
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= tdo_nxt;
      tdo_en <= in_shift;
    end
  end

endmodule

// File: rtl/jtag_status_tap_chk.sv
module jtag_status_tap_chk
  import jtag_tap_pkg::*;
(
  input logic            tck,
  input logic            trst_n,
  input logic            tms,
  input logic            tdo_en,
  input logic            st_ep_busy,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir_sr,
  input logic [IR_W-1:0] ir_q,
  input dr_sel_e         dr_sel,
  input logic            byp_q
);

  logic [2:0] ones;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)         ones <= '0;
    else if (!tms)       ones <= '0;
    else if (ones != 3'd5) ones <= ones + 3'd1;
  end

  a_r1_five_ones_reset: assert property (@(posedge tck) disable iff (!trst_n)
    (ones == 3'd5) |-> (state == TS_RESET));

  a_r1_reset_selects_ident: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_RESET) |=> (ir_q == OP_IDENT));

  a_r2_capture_fixed_bits: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_CAP_IR) |=> (ir_sr[1:0] == 2'b01 && ir_sr[15:9] == 7'd0));

  a_r4_capture_busy_bit: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_CAP_IR) |=> (ir_sr[4] == !$past(st_ep_busy)));

  a_r7_bypass_captures_zero: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_CAP_DR && dr_sel == DR_BYPASS) |=> (byp_q == 1'b0));

  a_r10_drive_only_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en |-> (state == TS_SH_IR || state == TS_SH_DR));

endmodule

bind jtag_status_tap jtag_status_tap_chk u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .tdo_en(tdo_en),
  .st_ep_busy(st_ep_busy), .state(state), .ir_sr(ir_sr), .ir_q(ir_q),
  .dr_sel(dr_sel), .byp_q(byp_q)
);

// File: tb/jtag_status_tap_bench.sv
module jtag_status_tap_bench;

  localparam int TCK_PERIOD = 10;
  localparam int NI = 2, NO = 2, NB = 2;
  localparam int LEN = 3*NB + 2*NO + NI;
  localparam logic [31:0] ID = 32'h1A5C_E093;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_en;
  logic st_isc_mode = 0, st_ep_busy = 0, st_isc_pass = 0, st_ep_pass = 0, st_rev_done = 0;
  logic [31:0] usercode = '0;
  logic usercode_valid = 0;
  logic [NI-1:0] pin_in = '0;
  logic [NO-1:0] core_out = '0, core_oe = '0, pad_out, pad_oe;
  logic [NB-1:0] core_bi_out = '0, core_bi_oe = '0, pad_bi_in = '0, pad_bi_out, pad_bi_oe;

  int n_chk = 0, n_bad = 0;
  logic shift_oe_ok;

  always #(TCK_PERIOD/2) tck = ~tck;

  jtag_status_tap #(.NI(NI), .NO(NO), .NB(NB), .ID_CODE(ID)) u_jtag_status_tap (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .st_isc_mode(st_isc_mode), .st_ep_busy(st_ep_busy), .st_isc_pass(st_isc_pass),
    .st_ep_pass(st_ep_pass), .st_rev_done(st_rev_done),
    .usercode(usercode), .usercode_valid(usercode_valid),
    .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
    .pad_out(pad_out), .pad_oe(pad_oe),
    .core_bi_out(core_bi_out), .core_bi_oe(core_bi_oe), .pad_bi_in(pad_bi_in),
    .pad_bi_out(pad_bi_out), .pad_bi_oe(pad_bi_oe)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge tck);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Inputs change just after a falling edge; tdo is read before the rising edge.
  task automatic step(input logic m, input logic d, output logic o);
    tms = m; tdi = d; o = tdo;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic to_idle();
    logic o;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
  endtask

  task automatic scan_ir(input logic [15:0] din, output logic [15:0] dout);
    logic o;
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    shift_oe_ok = 1'b1;
    for (int i = 0; i < 16; i++) begin
      if (!tdo_en) shift_oe_ok = 1'b0;
      step(i == 15, din[i], o);
      dout[i] = o;
    end
    step(1, 0, o); step(0, 0, o);
  endtask

  task automatic scan_dr(input logic [63:0] din, input int n, output logic [63:0] dout);
    logic o;
    dout = '0;
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < n; i++) begin
      step(i == n-1, din[i], o);
      dout[i] = o;
    end
    step(1, 0, o); step(0, 0, o);
  endtask

  function automatic logic [15:0] exp_status(input logic ip, input logic ep, input logic bz,
                                             input logic im, input logic dn);
    logic [15:0] e;
    e = 16'h0001;
    e[8] = ip; e[7] = !ip; e[6] = ep; e[5] = !ep;
    e[4] = !bz; e[3] = im; e[2] = dn;
    return e;
  endfunction

  function automatic logic [63:0] exp_chain();
    logic [63:0] v;
    v = '0;
    for (int j = 0; j < NB; j++) begin
      v[3*j] = core_bi_oe[j]; v[3*j+1] = core_bi_out[j]; v[3*j+2] = pad_bi_in[j];
    end
    for (int k = 0; k < NO; k++) begin
      v[3*NB+2*k] = core_oe[k]; v[3*NB+2*k+1] = core_out[k];
    end
    for (int m = 0; m < NI; m++) v[3*NB+2*NO+m] = pin_in[m];
    return v;
  endfunction

  initial begin
    logic [15:0] ir_out;
    logic [63:0] dout, din, e;
    logic o;
    logic [15:0] op;
    void'($urandom(32'd4711));

    repeat (2) @(posedge tck);
    @(negedge tck); #1;
    check("R10 reset tdo_en", {63'd0, tdo_en}, 64'd0);
    trst_n = 1'b1;
    step(0, 0, o);

    // R1/R5: identification without any instruction load
    scan_dr(64'd0, 32, dout);
    check("R1 R5 idcode after trst", dout, {32'd0, ID});
    check("R10 idle tdo_en", {63'd0, tdo_en}, 64'd0);

    // R2: captured pattern and LSB-first shift of the new instruction
    st_isc_pass = 1; st_ep_pass = 0; st_ep_busy = 1; st_isc_mode = 1; st_rev_done = 0;
    scan_ir(OP_BYPASS_C(), ir_out);
    check("R2 R3 R4 status capture", {48'd0, ir_out}, {48'd0, exp_status(1, 0, 1, 1, 0)});
    check("R10 tdo_en in shift-ir", {63'd0, shift_oe_ok}, 64'd1);
    scan_ir(16'h00FE, ir_out);
    check("R2 previous op not in capture", {48'd0, ir_out}, {48'd0, exp_status(1, 0, 1, 1, 0)});

    // R3/R4: random status flags
    for (int i = 0; i < 40; i++) begin
      logic [4:0] r;
      r = 5'($urandom);
      {st_isc_pass, st_ep_pass, st_ep_busy, st_isc_mode, st_rev_done} = r;
      scan_ir(16'h00FE, ir_out);
      check("R3 R4 random status", {48'd0, ir_out}, {48'd0, exp_status(r[4], r[3], r[2], r[1], r[0])});
    end

    // R1: five TMS-high cycles return to identification
    scan_ir(16'hFFFF, ir_out);
    to_idle();
    scan_dr(64'd0, 32, dout);
    check("R1 tms reset selects idcode", dout, {32'd0, ID});

    // R1: asynchronous trst
    scan_ir(16'hFFFF, ir_out);
    trst_n = 0; #2; trst_n = 1;
    step(0, 0, o);
    scan_dr(64'd0, 32, dout);
    check("R1 trst selects idcode", dout, {32'd0, ID});

    // R6: user code, both loaded and blank
    scan_ir(16'h00FD, ir_out);
    usercode_valid = 0; usercode = 32'h1234_5678;
    scan_dr(64'd0, 32, dout);
    check("R6 blank usercode", dout, 64'h0000_0000_FFFF_FFFF);
    for (int i = 0; i < 4; i++) begin
      usercode = $urandom; usercode_valid = 1;
      scan_dr(64'd0, 32, dout);
      check("R6 loaded usercode", dout, {32'd0, usercode});
    end

    // R7: bypass by defined and random unknown codes
    for (int i = 0; i < 12; i++) begin
      op = (i == 0) ? 16'hFFFF : 16'($urandom);
      if (op == 16'h0000 || op == 16'h0001 || op == 16'h00FE || op == 16'h00FD) op = 16'h1234;
      scan_ir(op, ir_out);
      din = {32'd0, 32'($urandom)};
      scan_dr(din, 20, dout);
      e = {din[62:0], 1'b0} & 64'hF_FFFF;
      check("R7 bypass one-bit delay", dout, e);
    end

    // R10: tdo holds across the rising edge and moves on the falling edge
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    tms = 0; tdi = 1;
    @(posedge tck); #1;
    check("R10 tdo stable after rising edge", {63'd0, tdo}, 64'd0);
    @(negedge tck); #1;
    check("R10 tdo moved on falling edge", {63'd0, tdo}, 64'd1);
    check("R10 tdo_en in shift-dr", {63'd0, tdo_en}, 64'd1);
    to_idle();

    // R8/R9: sample captures pins in the documented order, pads keep following core
    scan_ir(16'h0001, ir_out);
    for (int i = 0; i < 6; i++) begin
      {pin_in, core_out, core_oe, core_bi_out, core_bi_oe, pad_bi_in} = 12'($urandom);
      din = {52'd0, 12'($urandom)};
      scan_dr(din, LEN, dout);
      check("R8 chain order on sample", dout, exp_chain());
      check("R9 sample leaves pads on core",
            {56'd0, pad_out, pad_oe, pad_bi_out, pad_bi_oe},
            {56'd0, core_out, core_oe, core_bi_out, core_bi_oe});
    end

    // R9: extest drives pads from update cells
    scan_ir(16'h0000, ir_out);
    for (int i = 0; i < 4; i++) begin
      logic [NO-1:0] eo, ee;
      logic [NB-1:0] bo, be;
      din = {52'd0, 12'($urandom)};
      scan_dr(din, LEN, dout);
      for (int k = 0; k < NO; k++) begin eo[k] = din[3*NB+2*k+1]; ee[k] = din[3*NB+2*k]; end
      for (int j = 0; j < NB; j++) begin bo[j] = din[3*j+1]; be[j] = din[3*j]; end
      check("R9 R8 extest pads", {56'd0, pad_out, pad_oe, pad_bi_out, pad_bi_oe},
            {56'd0, eo, ee, bo, be});
    end

    summary();
  end

  function automatic logic [15:0] OP_BYPASS_C();
    return 16'hFFFF;
  endfunction

endmodule